// File: doc/BRIEF.md
# Zero-Overhead Loop and Repeat Sequencer

This block picks the program counter that a DSP core fetches next. The core reports each completed instruction: its address, whether it was one or two 16-bit words long, whether it redirected the flow, and any loop or repeat command it carried. From this the sequencer chooses one of four next addresses: the sequential one, the branch target, a held address that re-runs a repeated instruction, or a jump back to the start of a hardware loop.

Nested hardware loops are kept in three stacks that move together. One holds the address of the first body instruction, one the address of the last, and one the remaining pass count. A separate counter handles repetition of a single instruction. A loop-end comparison is made only when that counter has run down, and only while at least one loop is active. When the pass count of the innermost loop expires, all three stacks drop their top together and execution falls through past the loop end.

Top module: `zol_seq`

## Requirements
- R1: A completed instruction with `taken_i` high yields `next_pc_o == target_i`. The repeat counter and the stacks do not change, and any loop or repeat command on the same cycle is ignored.
- R2: With `step_i` low, `next_pc_o` equals `pc_i` and no state changes.
- R3: A plain instruction that is not repeated and not at an active loop end gives `pc_i + 1` when `len2_i` is 0 and `pc_i + 2` when `len2_i` is 1. This includes the case where loops are active but `pc_i` differs from the end-stack top.
- R4: A repeat command with count N advances to `pc_i + len` and makes the following instruction run max(N,1) times. The counter is decremented at each completed instruction, and `next_pc_o` stays at `pc_i` while the decremented value is non-zero.
- R5: A loop command with a non-zero count pushes three values in one cycle: start = `pc_i + len`, end = `loop_end_i` and count = `loop_cnt_i`. It advances to `pc_i + len`, and `empty_o` goes low.
- R6: A loop command with count 0 pushes nothing and gives `next_pc_o = loop_end_i + 1`.
- R7: At an active loop end (`pc_i` equals the end top, repeat counter at zero), a count that is still non-zero after decrement is written back to the count top, and `next_pc_o` becomes the start top.
- R8: When that decrement reaches zero, all three stacks pop together and `next_pc_o = pc_i + 1`, even for a two-word instruction.
- R9: The loop-end check waits for the repeat counter to run down. A repeated instruction at the loop end is held until its final run, and only that final run performs the loop-end step.
- R10: Loops nest. After the inner loop exits, the tops show the outer loop again.
- R11: Each stack holds 4 entries. A loop push while full is dropped, leaves the tops unchanged, and sets `ovf_o`. `ovf_o` stays set until reset.
- R12: A synchronous reset empties the stacks (`empty_o` = 1, tops read 0), clears `ovf_o` and clears the repeat counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | An instruction completes this cycle |
| pc_i | input | 16 | Address of the completing instruction |
| len2_i | input | 1 | Instruction is two words long |
| taken_i | input | 1 | Instruction transferred control |
| target_i | input | 16 | Branch destination |
| rep_start_i | input | 1 | Instruction is a repeat command |
| rep_cnt_i | input | 16 | Repeat count |
| loop_push_i | input | 1 | Instruction opens a hardware loop |
| loop_end_i | input | 16 | Address of the last body instruction |
| loop_cnt_i | input | 16 | Loop pass count |
| next_pc_o | output | 16 | Next fetch address |
| empty_o | output | 1 | No loop active |
| ovf_o | output | 1 | Sticky stack overflow |
| top_start_o | output | 16 | Start-stack top (0 when empty) |
| top_end_o | output | 16 | End-stack top (0 when empty) |
| top_cnt_o | output | 16 | Count-stack top (0 when empty) |

## Verification
The hardest case to reach is a repeated instruction that is also the last instruction of a loop body. Here the hold decision and the loop-end decision fall on the same address in consecutive runs. The bench opens a loop whose end address is the instruction right after a repeat command inside the body. It then checks that the early runs hold the address and leave the count unchanged, and that only the final run jumps back with the count reduced. Overflow is reached by opening four loops in a row, without executing any body, before a fifth push is attempted.

// File: rtl/zol_pkg.sv
package zol_pkg;
    localparam int ZOL_AW = 16;
    localparam int ZOL_CW = 16;

    typedef struct packed {
        logic [ZOL_AW-1:0] start;
        logic [ZOL_AW-1:0] fin;
        logic [ZOL_CW-1:0] cnt;
    } zol_frame_t;
endpackage

// File: rtl/zol_stack.sv
module zol_stack
    import zol_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              cnt_wr_i,
    input  logic [ZOL_CW-1:0] cnt_i,
    input  zol_frame_t        frame_i,
    output zol_frame_t        top_o,
    output logic              empty_o,
    output logic              ovf_o
);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        zol_frame_t [DEPTH-1:0] mem;
        logic [LW-1:0]          lvl;
        logic                   ovf;
    } stk_t;

    stk_t st_d, st_q;
    logic full;
    logic empty;

    assign full    = (st_q.lvl == LW'(DEPTH));
    assign empty   = (st_q.lvl == '0);
    assign empty_o = empty;
    assign ovf_o   = st_q.ovf;

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.lvl == LW'(i + 1)) top_o = st_q.mem[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            if (full) begin
                st_d.ovf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_q.lvl == LW'(i)) st_d.mem[i] = frame_i;
                end
                st_d.lvl = st_q.lvl + LW'(1);
            end
        end else if (pop_i && !empty) begin
            st_d.lvl = st_q.lvl - LW'(1);
        end else if (cnt_wr_i && !empty) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.lvl == LW'(i + 1)) st_d.mem[i].cnt = cnt_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/zol_repeat.sv
module zol_repeat
    import zol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ZOL_CW-1:0] load_val_i,
    input  logic              dec_i,
    output logic [ZOL_CW-1:0] remain_o
);
    logic [ZOL_CW-1:0] cnt_d, cnt_q;

    assign remain_o = (cnt_q == '0) ? '0 : cnt_q - ZOL_CW'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                   cnt_d = load_val_i;
        else if (dec_i && cnt_q != '0) cnt_d = remain_o;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [ZOL_AW-1:0] pc_i,
    input  logic              len2_i,
    input  logic              taken_i,
    input  logic [ZOL_AW-1:0] target_i,
    input  logic              rep_start_i,
    input  logic [ZOL_CW-1:0] rep_cnt_i,
    input  logic              loop_push_i,
    input  logic [ZOL_AW-1:0] loop_end_i,
    input  logic [ZOL_CW-1:0] loop_cnt_i,
    output logic [ZOL_AW-1:0] next_pc_o,
    output logic              empty_o,
    output logic              ovf_o,
    output logic [ZOL_AW-1:0] top_start_o,
    output logic [ZOL_AW-1:0] top_end_o,
    output logic [ZOL_CW-1:0] top_cnt_o
);
    typedef struct packed {
        logic [ZOL_AW-1:0] pc;
        logic              push;
        logic              pop;
        logic              cnt_wr;
        logic [ZOL_CW-1:0] cnt;
        logic              rep_load;
        logic              rep_dec;
    } ctl_t;

    ctl_t              ctl_d;
    zol_frame_t        top, frame;
    logic [ZOL_CW-1:0] rep_left;
    logic [ZOL_AW-1:0] seq_pc;
    logic [ZOL_CW-1:0] dec_cnt;
    logic              at_end;

    assign seq_pc  = pc_i + (len2_i ? ZOL_AW'(2) : ZOL_AW'(1));
    assign dec_cnt = top.cnt - ZOL_CW'(1);
    assign at_end  = !empty_o && (pc_i == top.fin);
    assign frame   = '{start: seq_pc, fin: loop_end_i, cnt: loop_cnt_i};

    always_comb begin
        ctl_d    = '0;
        ctl_d.pc = pc_i;
        if (step_i) begin
            if (taken_i) begin
                ctl_d.pc = target_i;
            end else if (loop_push_i) begin
                if (loop_cnt_i == '0) begin
                    ctl_d.pc = loop_end_i + ZOL_AW'(1);
                end else begin
                    ctl_d.push = 1'b1;
                    ctl_d.pc   = seq_pc;
                end
            end else if (rep_start_i) begin
                ctl_d.rep_load = 1'b1;
                ctl_d.pc       = seq_pc;
            end else begin
                ctl_d.rep_dec = 1'b1;
                if (rep_left != '0) begin
                    ctl_d.pc = pc_i;
                end else if (at_end) begin
                    if (dec_cnt != '0) begin
                        ctl_d.cnt_wr = 1'b1;
                        ctl_d.cnt    = dec_cnt;
                        ctl_d.pc     = top.start;
                    end else begin
                        ctl_d.pop = 1'b1;
                        ctl_d.pc  = pc_i + ZOL_AW'(1);
                    end
                end else begin
                    ctl_d.pc = seq_pc;
                end
            end
        end
    end

    zol_stack #(.DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push_i   (ctl_d.push),
        .pop_i    (ctl_d.pop),
        .cnt_wr_i (ctl_d.cnt_wr),
        .cnt_i    (ctl_d.cnt),
        .frame_i  (frame),
        .top_o    (top),
        .empty_o  (empty_o),
        .ovf_o    (ovf_o)
    );

    zol_repeat u_rep (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl_d.rep_load),
        .load_val_i (rep_cnt_i),
        .dec_i      (ctl_d.rep_dec),
        .remain_o   (rep_left)
    );

    assign next_pc_o   = ctl_d.pc;
    assign top_start_o = top.start;
    assign top_end_o   = top.fin;
    assign top_cnt_o   = top.cnt;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk
    import zol_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step_i,
    input logic              taken_i,
    input logic              rep_start_i,
    input logic              loop_push_i,
    input logic [ZOL_AW-1:0] pc_i,
    input logic [ZOL_AW-1:0] target_i,
    input logic [ZOL_AW-1:0] next_pc_o,
    input logic              empty_o,
    input logic              ovf_o,
    input logic [ZOL_CW-1:0] top_cnt_o,
    input logic [ZOL_CW-1:0] rep_cnt,
    input logic              full
);
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
        step_i && taken_i |-> next_pc_o == target_i); // R1
    AST_TAKEN_FREEZE: assert property (@(posedge clk) disable iff (rst)
        step_i && taken_i |=> $stable(rep_cnt) && $stable(empty_o) && $stable(top_cnt_o)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_i |-> next_pc_o == pc_i); // R2
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(rep_cnt) && $stable(empty_o) && $stable(top_cnt_o) && $stable(ovf_o)); // R2
    AST_REP_HOLD: assert property (@(posedge clk) disable iff (rst)
        step_i && !taken_i && !rep_start_i && !loop_push_i && rep_cnt > ZOL_CW'(1)
        |-> next_pc_o == pc_i); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R11
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(full) && $past(loop_push_i)); // R11
endmodule

bind zol_seq zol_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .taken_i     (taken_i),
    .rep_start_i (rep_start_i),
    .loop_push_i (loop_push_i),
    .pc_i        (pc_i),
    .target_i    (target_i),
    .next_pc_o   (next_pc_o),
    .empty_o     (empty_o),
    .ovf_o       (ovf_o),
    .top_cnt_o   (top_cnt_o),
    .rep_cnt     (u_rep.cnt_q),
    .full        (u_stk.full)
);

// File: tb/sim_zol_seq.sv
`timescale 1ns/100ps
module sim_zol_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0, len2_i = 1'b0, taken_i = 1'b0;
    logic        rep_start_i = 1'b0, loop_push_i = 1'b0;
    logic [15:0] pc_i = '0, target_i = '0, rep_cnt_i = '0, loop_end_i = '0, loop_cnt_i = '0;
    logic [15:0] next_pc_o, top_start_o, top_end_o, top_cnt_o;
    logic        empty_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zol_seq u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        step_i = 1'b0; taken_i = 1'b0; rep_start_i = 1'b0; loop_push_i = 1'b0; len2_i = 1'b0;
        #1;
    endtask

    task automatic stp(input logic [15:0] pc, input bit l2, input bit tk, input logic [15:0] tgt,
                       input bit rs, input logic [15:0] rn, input bit lp, input logic [15:0] le,
                       input logic [15:0] lc, input logic [15:0] exp, input string req);
        @(negedge clk);
        step_i = 1'b1; pc_i = pc; len2_i = l2; taken_i = tk; target_i = tgt;
        rep_start_i = rs; rep_cnt_i = rn; loop_push_i = lp; loop_end_i = le; loop_cnt_i = lc;
        #1;
        chk(req, "next_pc", {16'h0, next_pc_o}, {16'h0, exp});
    endtask

    task automatic ins(input logic [15:0] pc, input bit l2, input logic [15:0] exp, input string req);
        stp(pc, l2, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0, exp, req);
    endtask

    task automatic lpush(input logic [15:0] pc, input logic [15:0] le, input logic [15:0] lc,
                         input logic [15:0] exp, input string req);
        stp(pc, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, le, lc, exp, req);
    endtask

    task automatic rep(input logic [15:0] pc, input logic [15:0] n, input logic [15:0] exp, input string req);
        stp(pc, 1'b0, 1'b0, 16'h0, 1'b1, n, 1'b0, 16'h0, 16'h0, exp, req);
    endtask

    task automatic tops(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c,
                        input bit emp, input string req);
        chk(req, "top_start", {16'h0, top_start_o}, {16'h0, s});
        chk(req, "top_end",   {16'h0, top_end_o},   {16'h0, e});
        chk(req, "top_cnt",   {16'h0, top_cnt_o},   {16'h0, c});
        chk(req, "empty",     {31'h0, empty_o},     {31'h0, emp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_i = 1'b0; taken_i = 1'b0; rep_start_i = 1'b0; loop_push_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        tops(16'h0, 16'h0, 16'h0, 1'b1, "R12");
        chk("R12", "ovf", {31'h0, ovf_o}, 32'h0);
        ins(16'h0010, 1'b0, 16'h0011, "R12");
        idle();
    endtask

    task automatic t_seq();
        do_reset();
        ins(16'h0020, 1'b1, 16'h0022, "R3");
        ins(16'h0022, 1'b0, 16'h0023, "R3");
        idle();
        pc_i = 16'h0005;
        #1;
        chk("R2", "next_pc idle", {16'h0, next_pc_o}, 32'h5);
        tops(16'h0, 16'h0, 16'h0, 1'b1, "R2");
    endtask

    task automatic t_taken();
        do_reset();
        stp(16'h0030, 1'b0, 1'b1, 16'h0100, 1'b0, 16'h0, 1'b1, 16'h0040, 16'h0003, 16'h0100, "R1");
        stp(16'h0100, 1'b0, 1'b1, 16'h0200, 1'b1, 16'h0004, 1'b0, 16'h0, 16'h0, 16'h0200, "R1");
        idle();
        tops(16'h0, 16'h0, 16'h0, 1'b1, "R1");
        ins(16'h0200, 1'b0, 16'h0201, "R1");
        idle();
    endtask

    task automatic t_repeat();
        do_reset();
        rep(16'h0030, 16'd3, 16'h0031, "R4");
        ins(16'h0031, 1'b0, 16'h0031, "R4");
        ins(16'h0031, 1'b0, 16'h0031, "R4");
        ins(16'h0031, 1'b0, 16'h0032, "R4");
        rep(16'h0040, 16'd0, 16'h0041, "R4");
        ins(16'h0041, 1'b1, 16'h0043, "R4");
        idle();
    endtask

    task automatic t_loop();
        do_reset();
        lpush(16'h0050, 16'h0052, 16'd2, 16'h0051, "R5");
        idle();
        tops(16'h0051, 16'h0052, 16'd2, 1'b0, "R5");
        ins(16'h0051, 1'b0, 16'h0052, "R3");
        ins(16'h0052, 1'b1, 16'h0051, "R7");
        idle();
        tops(16'h0051, 16'h0052, 16'd1, 1'b0, "R7");
        ins(16'h0051, 1'b0, 16'h0052, "R7");
        ins(16'h0052, 1'b1, 16'h0053, "R8");
        idle();
        tops(16'h0, 16'h0, 16'h0, 1'b1, "R8");
    endtask

    task automatic t_zero();
        do_reset();
        lpush(16'h0060, 16'h0070, 16'd0, 16'h0071, "R6");
        idle();
        tops(16'h0, 16'h0, 16'h0, 1'b1, "R6");
    endtask

    task automatic t_nest();
        do_reset();
        lpush(16'h0080, 16'h0085, 16'd2, 16'h0081, "R10");
        lpush(16'h0081, 16'h0083, 16'd1, 16'h0082, "R10");
        idle();
        tops(16'h0082, 16'h0083, 16'd1, 1'b0, "R10");
        ins(16'h0082, 1'b0, 16'h0083, "R10");
        ins(16'h0083, 1'b0, 16'h0084, "R10");
        idle();
        tops(16'h0081, 16'h0085, 16'd2, 1'b0, "R10");
        ins(16'h0084, 1'b0, 16'h0085, "R10");
        ins(16'h0085, 1'b0, 16'h0081, "R10");
        idle();
        tops(16'h0081, 16'h0085, 16'd1, 1'b0, "R10");
    endtask

    task automatic t_rep_at_end();
        do_reset();
        lpush(16'h0090, 16'h0092, 16'd2, 16'h0091, "R9");
        rep(16'h0091, 16'd2, 16'h0092, "R9");
        ins(16'h0092, 1'b0, 16'h0092, "R9");
        idle();
        tops(16'h0091, 16'h0092, 16'd2, 1'b0, "R9");
        ins(16'h0092, 1'b0, 16'h0091, "R9");
        idle();
        tops(16'h0091, 16'h0092, 16'd1, 1'b0, "R9");
    endtask

    task automatic t_ovf();
        do_reset();
        for (int i = 0; i < 4; i++)
            lpush(16'(i), 16'(16'h10 + i), 16'd5, 16'(i + 1), "R11");
        idle();
        chk("R11", "ovf before", {31'h0, ovf_o}, 32'h0);
        lpush(16'h0004, 16'h0020, 16'd5, 16'h0005, "R11");
        idle();
        tops(16'h0004, 16'h0013, 16'd5, 1'b0, "R11");
        chk("R11", "ovf set", {31'h0, ovf_o}, 32'h1);
        ins(16'h0005, 1'b0, 16'h0006, "R11");
        idle();
        chk("R11", "ovf sticky", {31'h0, ovf_o}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_seq();
        t_taken();
        t_repeat();
        t_loop();
        t_zero();
        t_nest();
        t_rep_at_end();
        t_ovf();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule